// File: doc/BRIEF.md
# Double-Buffered Gamma Lookup Controller

This block keeps two copies of a per-channel transfer curve in two small lookup RAMs, bank A and bank B. Each bank has three planes: red, green and blue. Software fills the bank that the pixel path is not reading. When the new curve is complete, software programs the bank select. The pixel path switches banks only at the next frame-start pulse, so a frame never mixes two curves.

The host side is a simple register port with four word addresses:
- control: programmed mode, programmed bank select, readable active status and a sticky conflict flag.
- table control: a three-bit plane write mask and a host bank select.
- index: the write pointer.
- data.

Every data write stores into the planes the mask enables and then advances the index by one. The index stops at the last entry. The pixel side takes three channel samples per cycle. After one register stage it returns either the samples unchanged (bypass) or the stored entries that the top bits of each sample address.

Top module: `gamma_lut_ctrl`

## Requirements
- R1: After reset, every register field reads 0, both banks hold 0 in every entry, and the pixel outputs are 0.
- R2: Control register at address 0. Writable fields are mode in bits [1:0] and programmed bank select in bit 4. Read-only fields are active mode in [9:8], active bank in bit 12 and the conflict flag in bit 16. The programmed mode and select are copied into the active fields only in a cycle where `frame_start_i` is high.
- R3: Active mode 2 means table lookup. Any other active mode means bypass: each output channel equals its input one cycle after `pix_valid_i`.
- R4: In lookup mode, each output channel equals the entry of the active bank (select 0 is bank A, select 1 is bank B) in that channel's plane. The entry is addressed by the top log2(DEPTH) bits of the input sample. The output appears one cycle after `pix_valid_i`, and `pix_valid_o` follows `pix_valid_i` by one cycle.
- R5: Table control register at address 1 holds the plane write mask in bits [2:0] and the host bank select in bit 4. Mask bit 2 enables red, bit 1 green and bit 0 blue; a value of 7 writes all three planes. Host select 0 writes bank A and 1 writes bank B.
- R6: A write to the index register at address 2 loads the write pointer from bits [AW-1:0]. A value above DEPTH-1 is clamped to DEPTH-1. The index reads back at address 2.
- R7: A write to the data register at address 3 stores bits [DW-1:0] at the current index in every enabled plane of the host bank and leaves disabled planes unchanged. The index then advances by one but saturates at DEPTH-1, so further writes overwrite the last entry.
- R8: A data write that targets the active bank while the active mode is 2 is still performed, and it sets the sticky conflict flag. The check uses the active values from before any frame-start in that same cycle. Writing control with bit 16 set clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| host_we_i | input | 1 | register write strobe |
| host_addr_i | input | 2 | register write address |
| host_wdata_i | input | 32 | register write data |
| host_raddr_i | input | 2 | register read address |
| host_rdata_o | output | 32 | register read data, combinational |
| frame_start_i | input | 1 | frame boundary pulse |
| pix_valid_i | input | 1 | input sample valid |
| pix_r_i | input | DW | red sample |
| pix_g_i | input | DW | green sample |
| pix_b_i | input | DW | blue sample |
| pix_valid_o | output | 1 | output sample valid |
| pix_r_o | output | DW | red result |
| pix_g_o | output | DW | green result |
| pix_b_o | output | DW | blue result |

## Verification
A frame-start pulse and a host data write can land in the same cycle. The conflict decision must use the active bank from before the switch, not the bank that becomes active. The bench provokes this case by programming select 1, pointing the host at bank B while bank A is active, and then raising `frame_start_i` together with a data write. It judges the result in three ways: the conflict flag must stay clear, the active status must show bank B afterwards, and a full lookup sweep must return the word written in that cycle.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_LUTCTL = 2'd1,
    REG_INDEX  = 2'd2,
    REG_DATA   = 2'd3
  } reg_addr_e;

  localparam logic [1:0] MODE_RAM = 2'd2;

  // plane order follows mask bit positions
  localparam int PL_B = 0;
  localparam int PL_G = 1;
  localparam int PL_R = 2;
  localparam int NUM_PL = 3;
endpackage

// File: rtl/lut_regs.sv
module lut_regs
  import gamma_lut_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        waddr_i,
  input  logic [31:0]       wdata_i,
  input  logic [1:0]        raddr_i,
  output logic [31:0]       rdata_o,
  input  logic              frame_start_i,
  output logic [1:0]        mode_cur_o,
  output logic              sel_cur_o,
  output logic              lut_we_o,
  output logic              lut_bank_o,
  output logic [NUM_PL-1:0] lut_mask_o,
  output logic [AW-1:0]     lut_idx_o,
  output logic [DW-1:0]     lut_wdata_o,
  output logic              conflict_o
);
  localparam logic [AW-1:0] IDX_MAX = AW'(DEPTH - 1);

  logic [1:0]        mode_q, mode_cur_q;
  logic              sel_q, sel_cur_q, host_sel_q, conflict_q;
  logic [NUM_PL-1:0] mask_q;
  logic [AW-1:0]     idx_q, idx_load;
  logic              data_wr;

  assign data_wr  = we_i && (waddr_i == REG_DATA);
  assign idx_load = (wdata_i[AW-1:0] > IDX_MAX) ? IDX_MAX : wdata_i[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= '0;
      sel_q      <= 1'b0;
      mode_cur_q <= '0;
      sel_cur_q  <= 1'b0;
      mask_q     <= '0;
      host_sel_q <= 1'b0;
      idx_q      <= '0;
      conflict_q <= 1'b0;
    end else begin
      if (frame_start_i) begin
        mode_cur_q <= mode_q;
        sel_cur_q  <= sel_q;
      end
      if (we_i) begin
        unique case (waddr_i)
          REG_CTRL: begin
            mode_q <= wdata_i[1:0];
            sel_q  <= wdata_i[4];
            if (wdata_i[16]) conflict_q <= 1'b0;
          end
          REG_LUTCTL: begin
            mask_q     <= wdata_i[2:0];
            host_sel_q <= wdata_i[4];
          end
          REG_INDEX: idx_q <= idx_load;
          default: begin
            if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
            if (mode_cur_q == MODE_RAM && host_sel_q == sel_cur_q) conflict_q <= 1'b1;
          end
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (raddr_i)
      REG_CTRL: begin
        rdata_o[1:0] = mode_q;
        rdata_o[4]   = sel_q;
        rdata_o[9:8] = mode_cur_q;
        rdata_o[12]  = sel_cur_q;
        rdata_o[16]  = conflict_q;
      end
      REG_LUTCTL: begin
        rdata_o[2:0] = mask_q;
        rdata_o[4]   = host_sel_q;
      end
      REG_INDEX: rdata_o[AW-1:0] = idx_q;
      default:   rdata_o = '0;
    endcase
  end

  assign mode_cur_o  = mode_cur_q;
  assign sel_cur_o   = sel_cur_q;
  assign lut_we_o    = data_wr;
  assign lut_bank_o  = host_sel_q;
  assign lut_mask_o  = mask_q;
  assign lut_idx_o   = idx_q;
  assign lut_wdata_o = wdata_i[DW-1:0];
  assign conflict_o  = conflict_q;
endmodule

// File: rtl/lut_bank.sv
module lut_bank
  import gamma_lut_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [NUM_PL-1:0]          mask_i,
  input  logic [AW-1:0]              waddr_i,
  input  logic [DW-1:0]              wdata_i,
  input  logic [NUM_PL-1:0][AW-1:0]  raddr_i,
  output logic [NUM_PL-1:0][DW-1:0]  rdata_o
);
  for (genvar p = 0; p < NUM_PL; p++) begin : g_plane
    logic [DW-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i && mask_i[p]) begin
        mem_q[waddr_i] <= wdata_i;
      end
    end
    assign rdata_o[p] = mem_q[raddr_i[p]];
  end
endmodule

// File: rtl/lut_pixel.sv
module lut_pixel
  import gamma_lut_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 mode_cur_i,
  input  logic                       sel_cur_i,
  input  logic                       valid_i,
  input  logic [NUM_PL-1:0][DW-1:0]  pix_i,
  output logic [NUM_PL-1:0][AW-1:0]  raddr_o,
  input  logic [NUM_PL-1:0][DW-1:0]  bank_a_i,
  input  logic [NUM_PL-1:0][DW-1:0]  bank_b_i,
  output logic                       valid_o,
  output logic [NUM_PL-1:0][DW-1:0]  pix_o
);
  logic [NUM_PL-1:0][DW-1:0] res;

  for (genvar p = 0; p < NUM_PL; p++) begin : g_ch
    assign raddr_o[p] = pix_i[p][DW-1 -: AW];
    assign res[p] = (mode_cur_i != MODE_RAM) ? pix_i[p] :
                    (sel_cur_i ? bank_b_i[p] : bank_a_i[p]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) pix_o <= res;
    end
  end
endmodule

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl
  import gamma_lut_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [1:0]    host_addr_i,
  input  logic [31:0]   host_wdata_i,
  input  logic [1:0]    host_raddr_i,
  output logic [31:0]   host_rdata_o,
  input  logic          frame_start_i,
  input  logic          pix_valid_i,
  input  logic [DW-1:0] pix_r_i,
  input  logic [DW-1:0] pix_g_i,
  input  logic [DW-1:0] pix_b_i,
  output logic          pix_valid_o,
  output logic [DW-1:0] pix_r_o,
  output logic [DW-1:0] pix_g_o,
  output logic [DW-1:0] pix_b_o
);
  logic [1:0]                mode_cur;
  logic                      sel_cur, lut_we, lut_bank, conflict;
  logic [NUM_PL-1:0]         lut_mask;
  logic [AW-1:0]             lut_idx;
  logic [DW-1:0]             lut_wdata;
  logic [NUM_PL-1:0][AW-1:0] raddr;
  logic [NUM_PL-1:0][DW-1:0] pix_in, pix_out, rd_a, rd_b;

  lut_regs #(.DEPTH(DEPTH), .DW(DW)) i_regs (
    .clk_i, .rst_ni,
    .we_i(host_we_i), .waddr_i(host_addr_i), .wdata_i(host_wdata_i),
    .raddr_i(host_raddr_i), .rdata_o(host_rdata_o),
    .frame_start_i,
    .mode_cur_o(mode_cur), .sel_cur_o(sel_cur),
    .lut_we_o(lut_we), .lut_bank_o(lut_bank), .lut_mask_o(lut_mask),
    .lut_idx_o(lut_idx), .lut_wdata_o(lut_wdata), .conflict_o(conflict)
  );

  lut_bank #(.DEPTH(DEPTH), .DW(DW)) i_bank_a (
    .clk_i, .rst_ni, .we_i(lut_we && !lut_bank), .mask_i(lut_mask),
    .waddr_i(lut_idx), .wdata_i(lut_wdata), .raddr_i(raddr), .rdata_o(rd_a)
  );

  lut_bank #(.DEPTH(DEPTH), .DW(DW)) i_bank_b (
    .clk_i, .rst_ni, .we_i(lut_we && lut_bank), .mask_i(lut_mask),
    .waddr_i(lut_idx), .wdata_i(lut_wdata), .raddr_i(raddr), .rdata_o(rd_b)
  );

  assign pix_in[PL_R] = pix_r_i;
  assign pix_in[PL_G] = pix_g_i;
  assign pix_in[PL_B] = pix_b_i;

  lut_pixel #(.DEPTH(DEPTH), .DW(DW)) i_pixel (
    .clk_i, .rst_ni, .mode_cur_i(mode_cur), .sel_cur_i(sel_cur),
    .valid_i(pix_valid_i), .pix_i(pix_in), .raddr_o(raddr),
    .bank_a_i(rd_a), .bank_b_i(rd_b), .valid_o(pix_valid_o), .pix_o(pix_out)
  );

  assign pix_r_o = pix_out[PL_R];
  assign pix_g_o = pix_out[PL_G];
  assign pix_b_o = pix_out[PL_B];
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
  parameter int DEPTH = 8,
  parameter int DW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_we_i,
  input logic [1:0]    host_addr_i,
  input logic [31:0]   host_wdata_i,
  input logic          frame_start_i,
  input logic          pix_valid_i,
  input logic [DW-1:0] pix_r_i,
  input logic          pix_valid_o,
  input logic [DW-1:0] pix_r_o,
  input logic [1:0]    mode_cur,
  input logic          sel_cur,
  input logic          lut_bank,
  input logic [AW-1:0] lut_idx,
  input logic          conflict
);
  AST_IDX_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lut_idx <= AW'(DEPTH - 1)); // R7
  AST_CUR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(mode_cur) && $stable(sel_cur)); // R2
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i && host_addr_i == 2'd3 && lut_idx != AW'(DEPTH - 1)
    |=> lut_idx == $past(lut_idx) + 1'b1); // R7
  AST_BYPASS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i && mode_cur != 2'd2 |=> pix_r_o == $past(pix_r_i)); // R3
  AST_VALID_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> pix_valid_o); // R4
  AST_CONFLICT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i && host_addr_i == 2'd3 && mode_cur == 2'd2 && lut_bank == sel_cur
    |=> conflict); // R8
  AST_CONFLICT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict && !(host_we_i && host_addr_i == 2'd0 && host_wdata_i[16])
    |=> conflict); // R8
endmodule

bind gamma_lut_ctrl gamma_lut_chk #(.DEPTH(DEPTH), .DW(DW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_we_i(host_we_i), .host_addr_i(host_addr_i),
  .host_wdata_i(host_wdata_i), .frame_start_i(frame_start_i),
  .pix_valid_i(pix_valid_i), .pix_r_i(pix_r_i), .pix_valid_o(pix_valid_o),
  .pix_r_o(pix_r_o), .mode_cur(mode_cur), .sel_cur(sel_cur),
  .lut_bank(lut_bank), .lut_idx(lut_idx), .conflict(conflict)
);

// File: tb/test_gamma_lut_ctrl.sv
module test_gamma_lut_ctrl;
  localparam int DEPTH = 8;
  localparam int DW = 12;
  localparam int AW = 3;

  logic clk = 0, rst_ni = 0;
  logic host_we = 0, frame_start = 0, pix_valid = 0;
  logic [1:0] host_addr = 0, host_raddr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic [DW-1:0] pr = 0, pg = 0, pb = 0, or_o, og_o, ob_o;
  logic pv_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // model: [bank][plane 0=b,1=g,2=r][entry]
  int exp_mem [2][3][DEPTH];
  int m_mode_cur = 0, m_sel_cur = 0;

  always #5 clk = ~clk;

  gamma_lut_ctrl #(.DEPTH(DEPTH), .DW(DW)) i_gamma_lut_ctrl (
    .clk_i(clk), .rst_ni, .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_raddr_i(host_raddr), .host_rdata_o(host_rdata),
    .frame_start_i(frame_start), .pix_valid_i(pix_valid),
    .pix_r_i(pr), .pix_g_i(pg), .pix_b_i(pb),
    .pix_valid_o(pv_o), .pix_r_o(or_o), .pix_g_o(og_o), .pix_b_o(ob_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    host_we = 1; host_addr = 2'(a); host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(input int a, input int exp, input string req);
    host_raddr = 2'(a);
    #1;
    chk(host_rdata == 32'(exp), req, host_rdata, exp);
  endtask

  task automatic frame();
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  function automatic int look(input int pl, input int v);
    if (m_mode_cur != 2) return v;
    return exp_mem[m_sel_cur][pl][v >> (DW - AW)];
  endfunction

  task automatic sweep(input string req);
    for (int v = 0; v < (1 << DW); v++) begin
      int r, g, b;
      r = v; g = v ^ 12'hfff; b = (v * 7) & 12'hfff;
      pr = 12'(r); pg = 12'(g); pb = 12'(b); pix_valid = 1;
      @(negedge clk);
      chk(pv_o == 1'b1, "R4 valid", pv_o, 1);
      chk(or_o == 12'(look(2, r)), req, or_o, look(2, r));
      chk(og_o == 12'(look(1, g)), req, og_o, look(1, g));
      chk(ob_o == 12'(look(0, b)), req, ob_o, look(0, b));
    end
    pix_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) for (int p = 0; p < 3; p++)
      for (int i = 0; i < DEPTH; i++) exp_mem[k][p][i] = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, 0, "R1 ctrl"); rd(1, 0, "R1 lutctl"); rd(2, 0, "R1 index");
    chk(or_o == 0 && og_o == 0 && ob_o == 0 && pv_o == 0, "R1 pix", or_o, 0);

    // R5/R7: all planes of bank A, overrun past last entry
    wr(1, 32'h7); rd(1, 7, "R5 lutctl");
    wr(2, 0);
    for (int k = 0; k < 10; k++) begin
      int idx;
      wr(3, k * 3 + 1);
      idx = (k < DEPTH) ? k : DEPTH - 1;
      for (int p = 0; p < 3; p++) exp_mem[0][p][idx] = k * 3 + 1;
    end
    rd(2, DEPTH - 1, "R7 index saturates");
    // R6 index load and clamp is trivially ok for power-of-2; check load
    wr(2, 5); rd(2, 5, "R6 index load");
    // green-only refill of bank A
    wr(1, 32'h2); wr(2, 0);
    for (int i = 0; i < DEPTH; i++) begin
      wr(3, 12'h800 + i * 5);
      exp_mem[0][1][i] = 12'h800 + i * 5;
    end
    rd(2, DEPTH - 1, "R7 index after plane fill");
    // blue-only into bank B
    wr(1, 32'h11); rd(1, 32'h11, "R5 host select B");
    wr(2, 0);
    for (int i = 0; i < DEPTH; i++) begin
      wr(3, 12'hf00 - i);
      exp_mem[1][0][i] = 12'hf00 - i;
    end

    // R2: programmed but not yet active
    wr(0, 32'h2);
    rd(0, 32'h2, "R2 no frame yet");
    sweep("R3 bypass before frame");
    frame();
    m_mode_cur = 2; m_sel_cur = 0;
    rd(0, 32'h202, "R2 active after frame");
    sweep("R4 lookup bank A");

    // R8 conflict: write active bank A
    wr(1, 32'h4); wr(2, 3); wr(3, 12'h123);
    exp_mem[0][2][3] = 12'h123;
    rd(0, 32'h10202, "R8 conflict set");
    sweep("R8 write still performed");
    wr(0, 32'h10002);
    rd(0, 32'h202, "R8 conflict cleared");

    // same cycle: frame switch to B and host write to B
    wr(0, 32'h12);
    wr(1, 32'h17); wr(2, 0);
    host_we = 1; host_addr = 2'd3; host_wdata = 12'h456; frame_start = 1;
    @(negedge clk);
    host_we = 0; frame_start = 0;
    for (int p = 0; p < 3; p++) exp_mem[1][p][0] = 12'h456;
    m_sel_cur = 1;
    rd(0, 32'h1212, "R8 no conflict on same-cycle switch");
    rd(2, 1, "R7 index after write");
    sweep("R4 lookup bank B");

    // R3: mode 1 is bypass
    wr(0, 32'h1); frame(); m_mode_cur = 1; m_sel_cur = 0;
    rd(0, 32'h101, "R2 mode 1 active");
    sweep("R3 bypass mode 1");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule